// File: doc/BRIEF.md
# Reduced 32-bit Integer Processor with LED Output Register

This block is a small 32-bit processor that completes one instruction per enabled clock. Fetch, decode, execute, memory access and register write-back all happen in the same cycle. It understands a deliberately narrow slice of the RV32I integer instruction set. It holds its own program in a built-in read-only store, so no external file is needed. It keeps data words in a small internal RAM.

The only thing the processor drives outward is a 16-bit LED port. Software sets this port with a word store to one fixed address. That store never reaches the RAM. The board clock is not divided into a new clock. A free-running counter raises an enable once every eighth edge, and every architectural register advances only on that edge.

A parameter selects the built-in program. The default program lights the pattern 0x5555 and then spins forever. A second, longer program exercises every supported instruction and reports each result on the LED port.

Top module: `rvl_core`

## Requirements
- R1: While rst_ni is low, the program counter is 0x00000000, the LED output is 0, all 31 writable registers are 0 and the enable counter is 0. This holds whether reset is applied at power-up or in the middle of a run.
- R2: Architectural state (program counter, registers, RAM, LED output) changes only on the enabled edge, which comes every DIV (default 8) clock edges. The first instruction completes on the DIV-th rising edge after reset is released.
- R3: The register-register operations use opcode 0110011. They are ADD and SUB (funct3 000, funct7 0x00 or 0x20), SLL (001), SLT (010), SLTU (011), XOR (100), SRL and SRA (101, funct7 0x00 or 0x20), OR (110) and AND (111). Shifts use only the low 5 bits of rs2. SLT compares as signed and SLTU as unsigned, and both give 0 or 1.
- R4: ADDI (opcode 0010011, funct3 000) adds the sign-extended 12-bit immediate to rs1. LUI (0110111) writes the 20-bit immediate into bits 31:12 and zeros below. AUIPC (0010111) writes PC plus that same value.
- R5: BEQ (opcode 1100011, funct3 000) and BNE (funct3 001) jump to PC plus the sign-extended 13-bit offset when rs1 equals rs2 (BEQ) or differs from it (BNE). Otherwise the next PC is PC+4.
- R6: JAL (1101111) jumps to PC plus the sign-extended 21-bit offset. JALR (1100111, funct3 000) jumps to (rs1 + imm) with bit 0 cleared. Both write PC+4 to rd.
- R7: LW (0000011, funct3 010) and SW (0100011, funct3 010) use address rs1 + imm. They reach a RAM of DMEM_WORDS words indexed by address bits [7:2] at the default depth, so addresses alias modulo 256 bytes.
- R8: An SW whose address equals 0x00007000 loads bits 15:0 of rs2 into the LED output and leaves the RAM word at the aliased index unchanged.
- R9: Register x0 always reads as zero. A write to it, such as ADDI x0,x0,7, has no effect.
- R10: Any other encoding behaves as a no-op that only advances the PC by 4. This covers other opcodes, other funct3 values of the branch, load, store, immediate and jump-register groups, and register-register funct7 values other than those in R3.
- R11: With the default program, the LED output stays 0 until the fourth instruction completes (the 32nd enabled-clock edge after reset release). It then reads 0x5555 and keeps that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Board clock; the core advances on every DIV-th rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| led_o | output | 16 | Memory-mapped LED output register |

## Verification
Two functions share one cycle here. Every store decodes both a RAM write and an LED register write, and the fixed LED address aliases onto RAM word 0 because only the low address bits index the RAM. The test program first stores a known value to RAM word 0, then stores a different value to the LED address, then loads word 0 back and shows it on the LEDs. A correct design reproduces the first value, and a design that also writes the RAM shows the second. A behavioural instruction-level model in the bench follows the same program and compares the LED port on every clock, so both the value and the edge on which it appears are judged.

// File: rtl/rvl_pkg.sv
package rvl_pkg;

  localparam logic [6:0] OPC_OP    = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [6:0] OPC_BR    = 7'b1100011;
  localparam logic [6:0] OPC_LD    = 7'b0000011;
  localparam logic [6:0] OPC_ST    = 7'b0100011;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_SLT, ALU_SLTU
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    use_imm;
    logic    a_pc;
    logic    a_zero;
    alu_op_e op;
    logic    is_br;
    logic    br_ne;
    logic    is_jal;
    logic    is_jalr;
    logic    ld;
    logic    st;
  } ctrl_t;

  function automatic logic [31:0] e_r(input logic [6:0] f7, input logic [4:0] rs2,
                                      input logic [4:0] rs1, input logic [2:0] f3,
                                      input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, OPC_OP};
  endfunction

  function automatic logic [31:0] e_i(input logic [11:0] imm, input logic [4:0] rs1,
                                      input logic [2:0] f3, input logic [4:0] rd,
                                      input logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [31:0] e_s(input logic [11:0] imm, input logic [4:0] rs2,
                                      input logic [4:0] rs1);
    return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], OPC_ST};
  endfunction

  function automatic logic [31:0] e_b(input logic [12:0] off, input logic [4:0] rs2,
                                      input logic [4:0] rs1, input logic [2:0] f3);
    return {off[12], off[10:5], rs2, rs1, f3, off[4:1], off[11], OPC_BR};
  endfunction

  function automatic logic [31:0] e_u(input logic [19:0] imm, input logic [4:0] rd,
                                      input logic [6:0] opc);
    return {imm, rd, opc};
  endfunction

  function automatic logic [31:0] e_j(input logic [20:0] off, input logic [4:0] rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, OPC_JAL};
  endfunction

  // LED demo: pattern 0x5555 to 0x7000, then spin
  function automatic logic [31:0] prog_demo(input int idx);
    case (idx)
      0: return e_u(20'h00007, 5'd5, OPC_LUI);
      1: return e_u(20'h00005, 5'd6, OPC_LUI);
      2: return e_i(12'h555, 5'd6, 3'b000, 5'd6, OPC_IMM);
      3: return e_s(12'd0, 5'd6, 5'd5);
      4: return e_j(21'd0, 5'd0);
      default: return 32'h0;
    endcase
  endfunction

  // instruction exercise program; every result lands on the LED port
  function automatic logic [31:0] prog_test(input int idx);
    case (idx)
      0:  return e_u(20'h00007, 5'd5, OPC_LUI);
      1:  return e_i(12'hFFD, 5'd0, 3'b000, 5'd1, OPC_IMM);
      2:  return e_i(12'd5, 5'd0, 3'b000, 5'd2, OPC_IMM);
      3:  return e_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd3);
      4:  return e_s(12'd0, 5'd3, 5'd5);
      5:  return e_r(7'h20, 5'd1, 5'd2, 3'b000, 5'd3);
      6:  return e_s(12'd0, 5'd3, 5'd5);
      7:  return e_r(7'h00, 5'd2, 5'd1, 3'b111, 5'd3);
      8:  return e_s(12'd0, 5'd3, 5'd5);
      9:  return e_r(7'h00, 5'd2, 5'd1, 3'b110, 5'd3);
      10: return e_s(12'd0, 5'd3, 5'd5);
      11: return e_r(7'h00, 5'd2, 5'd1, 3'b100, 5'd3);
      12: return e_s(12'd0, 5'd3, 5'd5);
      13: return e_i(12'd36, 5'd0, 3'b000, 5'd4, OPC_IMM);
      14: return e_r(7'h00, 5'd4, 5'd2, 3'b001, 5'd3);
      15: return e_s(12'd0, 5'd3, 5'd5);
      16: return e_r(7'h00, 5'd4, 5'd1, 3'b101, 5'd3);
      17: return e_s(12'd0, 5'd3, 5'd5);
      18: return e_r(7'h20, 5'd2, 5'd1, 3'b101, 5'd3);
      19: return e_s(12'd0, 5'd3, 5'd5);
      20: return e_r(7'h00, 5'd2, 5'd1, 3'b010, 5'd3);
      21: return e_s(12'd0, 5'd3, 5'd5);
      22: return e_r(7'h00, 5'd2, 5'd1, 3'b011, 5'd3);
      23: return e_s(12'd0, 5'd3, 5'd5);
      24: return e_u(20'h00001, 5'd3, OPC_AUIPC);
      25: return e_s(12'd0, 5'd3, 5'd5);
      26: return e_u(20'hABCDE, 5'd3, OPC_LUI);
      27: return e_r(7'h00, 5'd4, 5'd3, 3'b101, 5'd3);
      28: return e_s(12'd0, 5'd3, 5'd5);
      29: return e_i(12'd7, 5'd0, 3'b000, 5'd0, OPC_IMM);
      30: return e_s(12'd0, 5'd0, 5'd5);
      31: return e_b(13'd8, 5'd2, 5'd1, 3'b000);
      32: return e_i(12'h011, 5'd0, 3'b000, 5'd3, OPC_IMM);
      33: return e_s(12'd0, 5'd3, 5'd5);
      34: return e_b(13'd8, 5'd2, 5'd1, 3'b001);
      35: return e_i(12'h022, 5'd0, 3'b000, 5'd3, OPC_IMM);
      36: return e_s(12'd0, 5'd3, 5'd5);
      37: return e_b(13'd8, 5'd2, 5'd2, 3'b000);
      38: return e_s(12'd0, 5'd0, 5'd5);
      39: return e_j(21'd8, 5'd6);
      40: return e_i(12'h033, 5'd0, 3'b000, 5'd3, OPC_IMM);
      41: return e_s(12'd0, 5'd6, 5'd5);
      42: return e_i(12'd181, 5'd0, 3'b000, 5'd7, OPC_IMM);
      43: return e_i(12'd0, 5'd7, 3'b000, 5'd8, OPC_JALR);
      44: return e_s(12'd0, 5'd0, 5'd5);
      45: return e_s(12'd0, 5'd8, 5'd5);
      46: return e_i(12'h123, 5'd0, 3'b000, 5'd3, OPC_IMM);
      47: return e_s(12'd0, 5'd3, 5'd0);
      48: return e_i(12'h456, 5'd0, 3'b000, 5'd9, OPC_IMM);
      49: return e_s(12'd0, 5'd9, 5'd5);
      50: return e_i(12'd0, 5'd0, 3'b010, 5'd10, OPC_LD);
      51: return e_s(12'd0, 5'd10, 5'd5);
      52: return e_s(12'd8, 5'd9, 5'd0);
      53: return e_i(12'd8, 5'd0, 3'b010, 5'd11, OPC_LD);
      54: return e_i(12'd1, 5'd11, 3'b000, 5'd11, OPC_IMM);
      55: return e_s(12'd0, 5'd11, 5'd5);
      56: return 32'hFFFF_FFFF;
      57: return 32'h0000_0073;
      58: return e_b(13'd8, 5'd2, 5'd1, 3'b100);
      59: return e_i(12'h077, 5'd0, 3'b000, 5'd3, OPC_IMM);
      60: return e_s(12'd0, 5'd3, 5'd5);
      61: return e_j(21'd0, 5'd0);
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/rvl_tick.sv
module rvl_tick #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap
      a_r2_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/rvl_rom.sv
module rvl_rom #(
  parameter int PROG  = 0,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr_i,
  output logic [31:0]   data_o
);
  generate
    if (PROG == 0) begin : g_demo
      always_comb data_o = rvl_pkg::prog_demo(int'(addr_i));
    end else begin : g_test
      always_comb data_o = rvl_pkg::prog_test(int'(addr_i));
    end
  endgenerate
endmodule

// File: rtl/rvl_regs.sv
module rvl_regs #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [RW-1:0]   raddr_a_i,
  input  logic [RW-1:0]   raddr_b_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o
);
  logic [XLEN-1:0] q [NREG];

  assign q[0] = '0;

  generate
    for (genvar i = 1; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              q[i] <= '0;
        else if (we_i && waddr_i == RW'(i))       q[i] <= wdata_i;
      end
    end
  endgenerate

  assign rdata_a_o = q[raddr_a_i];
  assign rdata_b_o = q[raddr_b_i];
endmodule

// File: rtl/rvl_alu.sv
module rvl_alu
  import rvl_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] res_o
);
  logic [SHW-1:0] sh;
  assign sh = b_i[SHW-1:0];

  always_comb begin
    case (op_i)
      ALU_SUB:  res_o = a_i - b_i;
      ALU_AND:  res_o = a_i & b_i;
      ALU_OR:   res_o = a_i | b_i;
      ALU_XOR:  res_o = a_i ^ b_i;
      ALU_SLL:  res_o = a_i << sh;
      ALU_SRL:  res_o = a_i >> sh;
      ALU_SRA:  res_o = $unsigned($signed(a_i) >>> sh);
      ALU_SLT:  res_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      ALU_SLTU: res_o = {{(XLEN-1){1'b0}}, a_i < b_i};
      default:  res_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/rvl_core.sv
module rvl_core
  import rvl_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          NREG       = 32,
  parameter int          DIV        = 8,
  parameter int          IMEM_WORDS = 64,
  parameter int          DMEM_WORDS = 64,
  parameter int          LED_W      = 16,
  parameter logic [31:0] LED_ADDR   = 32'h0000_7000,
  parameter int          PROG       = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [LED_W-1:0] led_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam int RW  = $clog2(NREG);

  logic            tick;
  logic [XLEN-1:0] pc_q, pc_nxt, pc_inc;
  logic [31:0]     instr;
  logic [XLEN-1:0] imm, rs1_d, rs2_d, alu_a, alu_b, alu_res, wb_d, ld_d;
  logic [LED_W-1:0] led_q;
  ctrl_t           c;
  logic            br_take, led_hit;

  logic [6:0] opc, f7;
  logic [2:0] f3;
  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];

  rvl_tick #(.DIV(DIV)) u_tick (.clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  rvl_rom #(.PROG(PROG), .DEPTH(IMEM_WORDS)) u_rom (
    .addr_i(pc_q[IAW+1:2]), .data_o(instr));

  // decode; anything unmatched stays all-zero, i.e. a no-op
  always_comb begin
    c    = '0;
    c.op = ALU_ADD;
    case (opc)
      OPC_OP: begin
        if (f7 == 7'h00) begin
          c.rf_we = 1'b1;
          case (f3)
            3'b001:  c.op = ALU_SLL;
            3'b010:  c.op = ALU_SLT;
            3'b011:  c.op = ALU_SLTU;
            3'b100:  c.op = ALU_XOR;
            3'b101:  c.op = ALU_SRL;
            3'b110:  c.op = ALU_OR;
            3'b111:  c.op = ALU_AND;
            default: c.op = ALU_ADD;
          endcase
        end else if (f7 == 7'h20 && f3 == 3'b000) begin
          c.rf_we = 1'b1; c.op = ALU_SUB;
        end else if (f7 == 7'h20 && f3 == 3'b101) begin
          c.rf_we = 1'b1; c.op = ALU_SRA;
        end
      end
      OPC_IMM:   if (f3 == 3'b000) begin c.rf_we = 1'b1; c.use_imm = 1'b1; end
      OPC_LUI:   begin c.rf_we = 1'b1; c.use_imm = 1'b1; c.a_zero = 1'b1; end
      OPC_AUIPC: begin c.rf_we = 1'b1; c.use_imm = 1'b1; c.a_pc = 1'b1; end
      OPC_JAL:   begin c.rf_we = 1'b1; c.is_jal = 1'b1; end
      OPC_JALR:  if (f3 == 3'b000) begin
                   c.rf_we = 1'b1; c.use_imm = 1'b1; c.is_jalr = 1'b1;
                 end
      OPC_BR:    if (f3 == 3'b000 || f3 == 3'b001) begin
                   c.is_br = 1'b1; c.br_ne = f3[0];
                 end
      OPC_LD:    if (f3 == 3'b010) begin c.rf_we = 1'b1; c.use_imm = 1'b1; c.ld = 1'b1; end
      OPC_ST:    if (f3 == 3'b010) begin c.use_imm = 1'b1; c.st = 1'b1; end
      default: ;
    endcase
  end

  // immediate by format
  always_comb begin
    case (opc)
      OPC_ST:            imm = XLEN'($signed({instr[31:25], instr[11:7]}));
      OPC_BR:            imm = XLEN'($signed({instr[31], instr[7], instr[30:25],
                                              instr[11:8], 1'b0}));
      OPC_LUI, OPC_AUIPC: imm = XLEN'($signed({instr[31:12], 12'h000}));
      OPC_JAL:           imm = XLEN'($signed({instr[31], instr[19:12], instr[20],
                                              instr[30:21], 1'b0}));
      default:           imm = XLEN'($signed(instr[31:20]));
    endcase
  end

  rvl_regs #(.XLEN(XLEN), .NREG(NREG)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(tick && c.rf_we), .waddr_i(instr[7+:RW]), .wdata_i(wb_d),
    .raddr_a_i(instr[15+:RW]), .raddr_b_i(instr[20+:RW]),
    .rdata_a_o(rs1_d), .rdata_b_o(rs2_d));

  assign alu_a = c.a_pc ? pc_q : (c.a_zero ? '0 : rs1_d);
  assign alu_b = c.use_imm ? imm : rs2_d;

  rvl_alu #(.XLEN(XLEN)) u_alu (.a_i(alu_a), .b_i(alu_b), .op_i(c.op), .res_o(alu_res));

  assign pc_inc  = pc_q + XLEN'(4);
  assign br_take = c.is_br && ((rs1_d == rs2_d) ^ c.br_ne);

  always_comb begin
    if (c.is_jalr)               pc_nxt = {alu_res[XLEN-1:1], 1'b0};
    else if (c.is_jal || br_take) pc_nxt = pc_q + imm;
    else                         pc_nxt = pc_inc;
  end

  // data RAM, word addressed; the LED address is carved out of it
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [DAW-1:0]  didx;
  assign didx    = alu_res[DAW+1:2];
  assign led_hit = (alu_res == XLEN'(LED_ADDR));
  assign ld_d    = dmem[didx];

  always_ff @(posedge clk_i) begin
    if (tick && c.st && !led_hit) dmem[didx] <= rs2_d;
  end

  assign wb_d = (c.is_jal || c.is_jalr) ? pc_inc : (c.ld ? ld_d : alu_res);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      led_q <= '0;
    end else if (tick) begin
      pc_q <= pc_nxt;
      if (c.st && led_hit) led_q <= rs2_d[LED_W-1:0];
    end
  end

  assign led_o = led_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> ($stable(pc_q) && $stable(led_q)));

  a_r5_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !c.is_jal && !c.is_jalr && !br_take) |=> pc_q == $past(pc_q) + XLEN'(4));

  a_r6_jalr_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && c.is_jalr) |=> !pc_q[0]);

  a_r8_led_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && c.st && led_hit) |=> led_q == $past(rs2_d[LED_W-1:0]));

  a_r3_cmp_bool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c.rf_we && (c.op == ALU_SLT || c.op == ALU_SLTU)) |-> alu_res[XLEN-1:1] == '0);
endmodule

// File: tb/rvl_core_test.sv
module rvl_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] led_t, led_d;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rvl_core #(.PROG(1)) uut      (.clk_i(clk), .rst_ni(rst_n), .led_o(led_t));
  rvl_core             uut_demo (.clk_i(clk), .rst_ni(rst_n), .led_o(led_d));

  // ---------------- bench's own encoders and program image ----------------
  function automatic logic [31:0] a_r(int f7, int rs2, int rs1, int f3, int rd);
    return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'h33};
  endfunction
  function automatic logic [31:0] a_i(int imm, int rs1, int f3, int rd, int opc);
    return {12'(imm), 5'(rs1), 3'(f3), 5'(rd), 7'(opc)};
  endfunction
  function automatic logic [31:0] a_s(int imm, int rs2, int rs1);
    logic [11:0] m; m = 12'(imm);
    return {m[11:5], 5'(rs2), 5'(rs1), 3'b010, m[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] a_b(int off, int rs2, int rs1, int f3);
    logic [12:0] m; m = 13'(off);
    return {m[12], m[10:5], 5'(rs2), 5'(rs1), 3'(f3), m[4:1], m[11], 7'h63};
  endfunction
  function automatic logic [31:0] a_u(int imm, int rd, int opc);
    return {20'(imm), 5'(rd), 7'(opc)};
  endfunction
  function automatic logic [31:0] a_j(int off, int rd);
    logic [20:0] m; m = 21'(off);
    return {m[20], m[10:1], m[11], m[19:12], 5'(rd), 7'h6F};
  endfunction

  function automatic logic [31:0] tprog(int i);
    case (i)
      0:  return a_u(7, 5, 'h37);
      1:  return a_i(-3, 0, 0, 1, 'h13);
      2:  return a_i(5, 0, 0, 2, 'h13);
      3:  return a_r(0, 2, 1, 0, 3);
      4:  return a_s(0, 3, 5);
      5:  return a_r('h20, 1, 2, 0, 3);
      6:  return a_s(0, 3, 5);
      7:  return a_r(0, 2, 1, 7, 3);
      8:  return a_s(0, 3, 5);
      9:  return a_r(0, 2, 1, 6, 3);
      10: return a_s(0, 3, 5);
      11: return a_r(0, 2, 1, 4, 3);
      12: return a_s(0, 3, 5);
      13: return a_i(36, 0, 0, 4, 'h13);
      14: return a_r(0, 4, 2, 1, 3);
      15: return a_s(0, 3, 5);
      16: return a_r(0, 4, 1, 5, 3);
      17: return a_s(0, 3, 5);
      18: return a_r('h20, 2, 1, 5, 3);
      19: return a_s(0, 3, 5);
      20: return a_r(0, 2, 1, 2, 3);
      21: return a_s(0, 3, 5);
      22: return a_r(0, 2, 1, 3, 3);
      23: return a_s(0, 3, 5);
      24: return a_u(1, 3, 'h17);
      25: return a_s(0, 3, 5);
      26: return a_u('hABCDE, 3, 'h37);
      27: return a_r(0, 4, 3, 5, 3);
      28: return a_s(0, 3, 5);
      29: return a_i(7, 0, 0, 0, 'h13);
      30: return a_s(0, 0, 5);
      31: return a_b(8, 2, 1, 0);
      32: return a_i('h11, 0, 0, 3, 'h13);
      33: return a_s(0, 3, 5);
      34: return a_b(8, 2, 1, 1);
      35: return a_i('h22, 0, 0, 3, 'h13);
      36: return a_s(0, 3, 5);
      37: return a_b(8, 2, 2, 0);
      38: return a_s(0, 0, 5);
      39: return a_j(8, 6);
      40: return a_i('h33, 0, 0, 3, 'h13);
      41: return a_s(0, 6, 5);
      42: return a_i(181, 0, 0, 7, 'h13);
      43: return a_i(0, 7, 0, 8, 'h67);
      44: return a_s(0, 0, 5);
      45: return a_s(0, 8, 5);
      46: return a_i('h123, 0, 0, 3, 'h13);
      47: return a_s(0, 3, 0);
      48: return a_i('h456, 0, 0, 9, 'h13);
      49: return a_s(0, 9, 5);
      50: return a_i(0, 0, 2, 10, 'h03);
      51: return a_s(0, 10, 5);
      52: return a_s(8, 9, 0);
      53: return a_i(8, 0, 2, 11, 'h03);
      54: return a_i(1, 11, 0, 11, 'h13);
      55: return a_s(0, 11, 5);
      56: return 32'hFFFF_FFFF;
      57: return 32'h0000_0073;
      58: return a_b(8, 2, 1, 4);
      59: return a_i('h77, 0, 0, 3, 'h13);
      60: return a_s(0, 3, 5);
      61: return a_j(0, 0);
      default: return 32'h0;
    endcase
  endfunction

  // ---------------- behavioural instruction-level reference ----------------
  logic [31:0] m_pc;
  logic [31:0] m_x [32];
  logic [31:0] m_ram [64];
  logic [15:0] m_led;
  int          m_cnt;
  string       m_tag = "R1";

  task automatic m_reset();
    m_pc = 0; m_led = 0; m_cnt = 0; m_tag = "R1";
    for (int i = 0; i < 32; i++) m_x[i] = 0;
  endtask

  task automatic m_step();
    logic [31:0] w, a, b, ii, si, bi, ui, ji, res, nxt;
    int rd;
    bit wr;
    w  = tprog(int'(m_pc[7:2]));
    a  = m_x[w[19:15]];
    b  = m_x[w[24:20]];
    rd = int'(w[11:7]);
    ii = {{20{w[31]}}, w[31:20]};
    si = {{20{w[31]}}, w[31:25], w[11:7]};
    bi = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
    ui = {w[31:12], 12'h0};
    ji = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
    nxt = m_pc + 4; wr = 0; res = 0; m_tag = "R10";
    case (w[6:0])
      7'h33: begin
        m_tag = "R3"; wr = 1;
        if (w[31:25] == 7'h00) begin
          case (w[14:12])
            0: res = a + b;
            1: res = a << b[4:0];
            2: res = ($signed(a) < $signed(b)) ? 1 : 0;
            3: res = (a < b) ? 1 : 0;
            4: res = a ^ b;
            5: res = a >> b[4:0];
            6: res = a | b;
            default: res = a & b;
          endcase
        end else if (w[31:25] == 7'h20 && w[14:12] == 0) res = a - b;
        else if (w[31:25] == 7'h20 && w[14:12] == 5) res = $signed(a) >>> b[4:0];
        else begin wr = 0; m_tag = "R10"; end
      end
      7'h13: if (w[14:12] == 0) begin m_tag = "R4"; wr = 1; res = a + ii; end
      7'h37: begin m_tag = "R4"; wr = 1; res = ui; end
      7'h17: begin m_tag = "R4"; wr = 1; res = m_pc + ui; end
      7'h6F: begin m_tag = "R6"; wr = 1; res = m_pc + 4; nxt = m_pc + ji; end
      7'h67: if (w[14:12] == 0) begin
               m_tag = "R6"; wr = 1; res = m_pc + 4; nxt = (a + ii) & ~32'h1;
             end
      7'h63: if (w[14:12] == 0 || w[14:12] == 1) begin
               m_tag = "R5";
               if ((a == b) != w[12]) nxt = m_pc + bi;
             end
      7'h03: if (w[14:12] == 2) begin m_tag = "R7"; wr = 1; res = m_ram[(a + ii) >> 2 & 63]; end
      7'h23: if (w[14:12] == 2) begin
               if (a + si == 32'h7000) begin m_tag = "R8"; m_led = b[15:0]; end
               else begin m_tag = "R7"; m_ram[(a + si) >> 2 & 63] = b; end
             end
      default: ;
    endcase
    if (wr && rd != 0) m_x[rd] = res;
    if (wr && rd == 0) m_tag = "R9";
    m_pc = nxt;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      if (m_cnt == 7) m_step();  // R2: one instruction every eighth edge
      m_cnt = (m_cnt + 1) % 8;
    end
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s led actual=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  // per-clock compare against the reference, tagged with the last instruction class
  always @(negedge clk) if (rst_n) chk(m_tag, led_t, m_led);

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    chk("R1", led_t, 16'h0000);
    chk("R1", led_d, 16'h0000);
    rst_n = 1'b1;
    // R11: demo program result appears after the 32nd edge, not before
    repeat (31) @(posedge clk);
    @(negedge clk);
    chk("R11", led_d, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    chk("R11", led_d, 16'h5555);
    repeat (600) @(negedge clk);
    chk("R10", led_t, 16'h0077);
    chk("R11", led_d, 16'h5555);
    // mid-run reset: R1
    repeat (13) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", led_t, 16'h0000);
    chk("R1", led_d, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: first completion lands on the 8th edge; store at idx 4 lands after 40
    repeat (39) @(posedge clk);
    @(negedge clk);
    chk("R2", led_t, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    chk("R3", led_t, 16'h0002);
    repeat (600) @(negedge clk);
    chk("R8", led_t, 16'h0077);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule